// File: doc/BRIEF.md
# Iterative Half-Adder Completion Adder

This block adds two unsigned operands using nothing but one bank of half adders and a per-bit two-way select. When a request arrives, the select passes the external operands, and each bit does a single half addition. After that the select switches to the block's own registered sum and carry vectors. The same bank runs again once per clock. Each pass moves every pending carry up one bit or absorbs it.

The loop stops on the first cycle in which the registered carry vector is entirely zero. At that point the sum register holds the result. The number of cycles therefore depends on the operands: operands with no carry chain finish almost at once, and a carry that ripples across the full width takes the longest. Any carry that leaves the top bit, in any pass, is collected in a sticky carry-out flag.

A caller raises the request with the operands applied and waits for the done level. The sum, carry-out and done outputs then stay unchanged until the request is lowered and raised again.

Top module: `iha_adder`

## Requirements
- R1: After a synchronous active-high reset, sum is 0, cout is 0 and done is 0.
- R2: A rising edge of req (req high at a clock edge where it was low at the previous edge) while the block is idle captures a and b at that edge. It also clears done, so done reads 0 in the cycle after the accepting edge.
- R3: When done is high, sum equals (a + b) modulo 2^WIDTH for the operands captured at the accepting edge.
- R4: When done is high, cout equals the carry out of the WIDTH-bit addition a + b. Carries leaving the top bit in any pass are ORed into cout, and cout is cleared when a new request is accepted.
- R5: Let k be the number of repeated half-add passes, after the first one, that are needed before every internal carry is zero. done is first high k+2 clock edges after the accepting edge, counting the accepting edge as the first.
- R6: For every operand pair, the total number of half-add passes is at most WIDTH+1, so done rises no later than WIDTH+2 edges after acceptance.
- R7: A rising req while the block is busy is ignored, and operand changes after acceptance have no effect. Once done, sum, cout and done hold their values while req stays high.
- R8: No bit ever holds a registered sum of 1 together with a registered carry-out of 1 to the next bit.
- R9: The block gives correct results at widths 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request; a rising edge while idle starts an addition |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Result, valid while done is high |
| cout | output | 1 | Carry out of the top bit, valid while done is high |
| done | output | 1 | Completion level, cleared on the next accepted request |

## Verification
A fault in the fed-back carry vector or in the select stage shows up at the ports in two ways: a wrong sum or cout, or a done that arrives in a different cycle from the one the recurrence predicts. The bench therefore compares both the result and the exact completion cycle, on three widths side by side. A stuck-busy control state shows up as done never rising within WIDTH+2 cycles. A carry that is lost at the top bit shows up only in cout, and only on operands that overflow, so such pairs are included on purpose.

// File: rtl/iha_pkg.sv
package iha_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/iha_cell.sv
module iha_cell (
    input  logic sel,
    input  logic ext_a,
    input  logic ext_b,
    input  logic fb_sum,
    input  logic fb_carry,
    output logic s,
    output logic c
);
    logic op_x;
    logic op_y;

    always_comb begin
        op_x = sel ? fb_sum   : ext_a;
        op_y = sel ? fb_carry : ext_b;
        s    = op_x ^ op_y;
        c    = op_x & op_y;
    end
endmodule

// File: rtl/iha_bank.sv
module iha_bank #(
    parameter int WIDTH = 8
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] ext_a,
    input  logic [WIDTH-1:0] ext_b,
    input  logic [WIDTH-1:0] fb_sum,
    input  logic [WIDTH-1:0] fb_carry,
    output logic [WIDTH-1:0] s_vec,
    output logic [WIDTH-1:0] c_vec
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        iha_cell u_cell (
            .sel      (sel),
            .ext_a    (ext_a[i]),
            .ext_b    (ext_b[i]),
            .fb_sum   (fb_sum[i]),
            .fb_carry (fb_carry[i]),
            .s        (s_vec[i]),
            .c        (c_vec[i])
        );
    end
endmodule

// File: rtl/iha_ctrl.sv
module iha_ctrl
    import iha_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic carry_zero,
    output logic sel,
    output logic load,
    output logic step,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 2);

    typedef struct packed {
        phase_e             phase;
        logic               req_prev;
        logic               done;
        logic [CNT_W-1:0]   iters;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req;
        load          = 1'b0;
        step          = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req && !st_q.req_prev) begin
                    load       = 1'b1;
                    st_d.phase = PH_RUN;
                    st_d.done  = 1'b0;
                    st_d.iters = CNT_W'(1);
                end
            end
            PH_RUN: begin
                if (carry_zero) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    step       = 1'b1;
                    st_d.iters = st_q.iters + CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, req_prev: 1'b0, done: 1'b0, iters: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel  = (st_q.phase == PH_RUN);
    assign done = st_q.done;

    // R6
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.iters) <= WIDTH + 1);

    // R7
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RUN && !carry_zero) |=> (st_q.phase == PH_RUN) && !st_q.done);
endmodule

// File: rtl/iha_adder.sv
module iha_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic [WIDTH-1:0] carry;
        logic             cout;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             sel;
    logic             load;
    logic             step;
    logic             carry_zero;
    logic [WIDTH-1:0] s_vec;
    logic [WIDTH-1:0] c_vec;

    assign carry_zero = (dp_q.carry == '0);

    iha_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .carry_zero (carry_zero),
        .sel        (sel),
        .load       (load),
        .step       (step),
        .done       (done)
    );

    iha_bank #(.WIDTH(WIDTH)) u_bank (
        .sel      (sel),
        .ext_a    (a),
        .ext_b    (b),
        .fb_sum   (dp_q.sum),
        .fb_carry (dp_q.carry),
        .s_vec    (s_vec),
        .c_vec    (c_vec)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.sum   = s_vec;
            dp_d.carry = {c_vec[WIDTH-2:0], 1'b0};
            dp_d.cout  = c_vec[WIDTH-1];
        end else if (step) begin
            dp_d.sum   = s_vec;
            dp_d.carry = {c_vec[WIDTH-2:0], 1'b0};
            dp_d.cout  = dp_q.cout | c_vec[WIDTH-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign sum  = dp_q.sum;
    assign cout = dp_q.cout;

    // R8
    ha_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_q.sum[WIDTH-2:0] & dp_q.carry[WIDTH-1:1]) == '0);

    // R5
    done_carry_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> carry_zero);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> $stable(sum) && $stable(cout));

    // R2
    load_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !done && sel);
endmodule

// File: tb/tb_iha_adder.sv
`timescale 1ns/1ps
module tb_iha_adder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [63:0] a_in = '0;
    logic [63:0] b_in = '0;

    logic [7:0]  s8;
    logic [15:0] s16;
    logic [31:0] s32;
    logic        c8, c16, c32, d8, d16, d32;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    iha_adder #(.WIDTH(8)) dut (
        .clk(clk), .rst(rst), .req(req), .a(a_in[7:0]), .b(b_in[7:0]),
        .sum(s8), .cout(c8), .done(d8));
    iha_adder #(.WIDTH(16)) dut16 (
        .clk(clk), .rst(rst), .req(req), .a(a_in[15:0]), .b(b_in[15:0]),
        .sum(s16), .cout(c16), .done(d16));
    iha_adder #(.WIDTH(32)) dut32 (
        .clk(clk), .rst(rst), .req(req), .a(a_in[31:0]), .b(b_in[31:0]),
        .sum(s32), .cout(c32), .done(d32));

    function automatic logic [63:0] wmask(int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    // repeated half-add passes after the first one (R5 model)
    function automatic int passes(logic [63:0] x, logic [63:0] y, int w);
        logic [63:0] m = wmask(w);
        logic [63:0] s = (x ^ y) & m;
        logic [63:0] c = ((x & y) << 1) & m;
        logic [63:0] t;
        int k = 0;
        while (c != 0) begin
            t = s & c;
            s = s ^ c;
            c = (t << 1) & m;
            k++;
        end
        return k;
    endfunction

    function automatic void check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic logic [63:0] out_sum(int idx);
        return (idx == 0) ? {56'd0, s8} : (idx == 1) ? {48'd0, s16} : {32'd0, s32};
    endfunction
    function automatic logic out_cout(int idx);
        return (idx == 0) ? c8 : (idx == 1) ? c16 : c32;
    endfunction
    function automatic logic out_done(int idx);
        return (idx == 0) ? d8 : (idx == 1) ? d16 : d32;
    endfunction

    task automatic run_op(input logic [63:0] x, input logic [63:0] y, input bit poke);
        int lat [3];
        int widths [3] = '{8, 16, 32};
        bit all_done;
        logic [63:0] m, tot;
        @(negedge clk);
        a_in = x;
        b_in = y;
        req  = 1'b1;
        lat  = '{0, 0, 0};
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (n == 1) begin
                for (int i = 0; i < 3; i++) check("R2 done cleared after accept", 64'(out_done(i)), 64'd0);
                if (poke) req = 1'b0;
            end
            if (n == 2 && poke) begin
                req  = 1'b1;
                a_in = ~x;
                b_in = ~y;
            end
            all_done = 1'b1;
            for (int i = 0; i < 3; i++) begin
                if (lat[i] == 0 && out_done(i)) lat[i] = n;
                if (lat[i] == 0) all_done = 1'b0;
            end
            if (all_done) break;
        end
        for (int i = 0; i < 3; i++) begin
            m   = wmask(widths[i]);
            tot = (x & m) + (y & m);
            check($sformatf("R3 R9 sum w%0d", widths[i]), out_sum(i), tot & m);
            check($sformatf("R4 cout w%0d", widths[i]), 64'(out_cout(i)), (tot >> widths[i]) & 64'd1);
            check($sformatf("R5 latency w%0d", widths[i]), 64'(lat[i]), 64'(passes(x, y, widths[i]) + 2));
            check($sformatf("R6 bound w%0d", widths[i]), 64'(lat[i] >= 1 && lat[i] <= widths[i] + 2), 64'd1);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                m   = wmask(widths[i]);
                tot = (x & m) + (y & m);
                check($sformatf("R7 sum held w%0d", widths[i]), out_sum(i), tot & m);
                check($sformatf("R7 cout held w%0d", widths[i]), 64'(out_cout(i)), (tot >> widths[i]) & 64'd1);
                check($sformatf("R7 done held w%0d", widths[i]), 64'(out_done(i)), 64'd1);
            end
        end
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        logic [63:0] ra, rb;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 sum8 reset", {56'd0, s8}, 64'd0);
        check("R1 sum32 reset", {32'd0, s32}, 64'd0);
        check("R1 cout reset", 64'({c8, c16, c32}), 64'd0);
        check("R1 done reset", 64'({d8, d16, d32}), 64'd0);

        run_op(64'd0, 64'd0, 1'b0);
        run_op({64{1'b1}}, 64'd1, 1'b0);
        run_op({32{2'b10}}, {32{2'b01}}, 1'b0);
        run_op({32{2'b10}}, {32{2'b10}}, 1'b0);
        run_op({64{1'b1}}, {64{1'b1}}, 1'b0);
        run_op({64{1'b1}}, 64'd1, 1'b1);
        for (int r = 0; r < 40; r++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if (r % 5 == 0) rb = ~ra + 64'(r % 3);
            run_op(ra, rb, 1'b0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule